// File: doc/BRIEF.md
# Power-Fail Supervisor Sequencer

This block is a synchronous controller. It turns three comparator flags into the supervision signals a processor needs. The flags are already digitised: the monitored input is above its trip level, the supply is above the supply trip point, and the supply is above the battery level. The outputs are:

- a non-maskable interrupt pulse with an output-enable flag that models the tri-state pad;
- a reset in both polarities;
- a RAM chip-enable gate that write-protects memory;
- power-fail flags in both polarities.

A mode input selects the processor type.

- **NMOS-style:** the processor is held in reset whenever the supply is below its trip point. When the supply crosses back above the trip point, the block issues an interrupt and a timed reset. The interrupt is tri-stated while the supply is low, to save the battery.
- **CMOS-style:** a supply drop never resets the processor. On power-up, the block waits for the monitored input to recover before it issues the timed reset.

In normal operation, the strobe input keeps a watchdog alive. A falling monitored input raises an interrupt. While that input stays low, each strobe raises another interrupt, so software can poll the input by strobing.

The controller has five named states:

| State | Meaning |
|---|---|
| SUP_OFF | supply below battery |
| SUP_LOWVCC | supply above battery but below its trip point |
| SUP_CWAIT | CMOS power-up, waiting for the monitored input |
| SUP_HOLD | timed reset |
| SUP_RUN | watchdog running |

Its transitions are:

- **power-good:** SUP_OFF to SUP_LOWVCC when the battery flag rises.
- **trip-nmos:** SUP_LOWVCC to SUP_HOLD when the supply flag rises in NMOS mode.
- **trip-cmos:** SUP_LOWVCC to SUP_CWAIT when the supply flag rises in CMOS mode.
- **input-good:** SUP_CWAIT to SUP_HOLD when the monitored input is high.
- **hold-done:** SUP_HOLD to SUP_RUN.
- **dog-bite:** SUP_RUN to SUP_HOLD when the watchdog expires.
- **brown-out:** any of SUP_CWAIT, SUP_HOLD or SUP_RUN to SUP_LOWVCC when the supply flag drops.
- **blackout:** any state to SUP_OFF when the battery flag drops.

The priority order is blackout, then brown-out, then the rest. Reset forces SUP_OFF.

Top module: `pwr_supervisor_seq`

## Requirements
- R1: When the monitored input flag goes from 1 to 0 while the block is in SUP_CWAIT, SUP_HOLD or SUP_RUN, nmi_n goes low in the next cycle and stays low for exactly NMI_W cycles.
- R2: A strobe rising edge (strobe sampled 0 then 1) while in_ok is 0, in SUP_CWAIT, SUP_HOLD or SUP_RUN, starts a new NMI_W-cycle interrupt pulse. A strobe while in_ok is 1 starts none.
- R3: In CMOS mode (mode_nmos = 0), the supply flag dropping never asserts rst_hi.
- R4: In NMOS mode (mode_nmos = 1), rst_hi is 1 and rst_lo_n is 0 from the cycle after vcc_ok is seen low, and for as long as the supply stays below its trip point.
- R5: ram_ce_n is 1 (writes blocked) in the cycle after vcc_ok or vbat_ok is seen low. It is 0 in SUP_CWAIT, SUP_HOLD and SUP_RUN.
- R6: pf is 1 and pf_n is 0 in the cycle after vbat_ok is seen 0. pf is 0 and pf_n is 1 in the cycle after vbat_ok is seen 1.
- R7: In NMOS mode, nmi_oe is 0 (interrupt pin released) while the supply is below its trip point. It is 1 otherwise, and always 1 in CMOS mode.
- R8: In NMOS mode, the cycle after vcc_ok rises starts an NMI_W-cycle interrupt pulse. Reset then remains asserted for exactly RST_HOLD cycles counted from that cycle, outlasting the pulse.
- R9: In CMOS mode, after the supply recovers, reset stays deasserted until in_ok is 1. Reset then asserts in the next cycle for exactly RST_HOLD cycles.
- R10: In SUP_RUN, if no strobe rising edge occurs for WDOG_CYC cycles, reset asserts for RST_HOLD cycles. The watchdog then restarts.
- R11: Every strobe rising edge in SUP_RUN restarts the watchdog period from the full WDOG_CYC cycles.
- R12: An interrupt trigger during an active pulse restarts the pulse, so it ends NMI_W cycles after the last trigger.
- R13: rst_lo_n is always the inverse of rst_hi.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, forces SUP_OFF |
| in_ok | input | 1 | Monitored input above its trip level |
| vcc_ok | input | 1 | Supply above its trip point |
| vbat_ok | input | 1 | Supply above battery level |
| mode_nmos | input | 1 | 1 = NMOS-style processor, 0 = CMOS-style |
| strobe | input | 1 | Watchdog strobe; rising edge counts |
| nmi_n | output | 1 | Active-low interrupt pulse (1 when released) |
| nmi_oe | output | 1 | Interrupt pad drive enable |
| rst_hi | output | 1 | Active-high processor reset |
| rst_lo_n | output | 1 | Active-low processor reset |
| ram_ce_n | output | 1 | RAM chip-enable gate, 1 blocks access |
| pf | output | 1 | Active-high power fail |
| pf_n | output | 1 | Active-low power fail |

## Verification
The bench builds the block with RST_HOLD = 8, WDOG_CYC = 20 and NMI_W = 3. With these values, several cases fit into a few hundred cycles of directed stimulus:

- a full watchdog expiry;
- a reset hold that clearly outlasts the interrupt pulse;
- a retriggered pulse whose length (five cycles instead of three) shows a restart rather than an extension.

Both processor modes are taken through power-up and power-down. The battery flag is also cycled.

// File: rtl/pss_pkg.sv
package pss_pkg;

    typedef enum logic [2:0] {
        SUP_OFF    = 3'd0,
        SUP_LOWVCC = 3'd1,
        SUP_CWAIT  = 3'd2,
        SUP_HOLD   = 3'd3,
        SUP_RUN    = 3'd4
    } sup_state_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pss_timer.sv
module pss_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          zero
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/pss_nmi_pulse.sv
module pss_nmi_pulse #(
    parameter int NMI_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic en,
    output logic active
);
    localparam int NW = $clog2(NMI_W + 1);
    localparam logic [NW-1:0] WLD = NW'(NMI_W);

    logic [NW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (trig) begin
            left_q <= WLD;
        end else if (!en) begin
            left_q <= '0;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign active = (left_q != '0);
endmodule

// File: rtl/pss_fsm.sv
module pss_fsm
    import pss_pkg::*;
#(
    parameter int CW       = 8,
    parameter int RST_HOLD = 200,
    parameter int WDOG_CYC = 1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_ok,
    input  logic          vcc_ok,
    input  logic          vbat_ok,
    input  logic          mode_nmos,
    input  logic          strobe,
    input  logic          tmr_zero,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          tmr_dec,
    output logic          nmi_trig,
    output logic          nmi_en,
    output logic          rst_act,
    output logic          ce_block,
    output logic          pwr_fail
);
    localparam logic [CW-1:0] HOLD_LD = CW'(RST_HOLD - 1);
    localparam logic [CW-1:0] WDOG_LD = CW'(WDOG_CYC - 1);

    sup_state_e state_q, state_d;
    logic in_prev_q, stb_prev_q;
    logic in_fall, stb_rise, supervised, low_side;

    assign in_fall    = in_prev_q & ~in_ok;
    assign stb_rise   = strobe & ~stb_prev_q;
    assign supervised = (state_q == SUP_CWAIT) || (state_q == SUP_HOLD) ||
                        (state_q == SUP_RUN);
    assign low_side   = (state_q == SUP_OFF) || (state_q == SUP_LOWVCC);

    // state register and edge history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= SUP_OFF;
            in_prev_q  <= 1'b0;
            stb_prev_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            in_prev_q  <= in_ok;
            stb_prev_q <= strobe;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SUP_OFF: begin
                if (vbat_ok) state_d = SUP_LOWVCC;          // power-good
            end
            SUP_LOWVCC: begin
                if (!vbat_ok)                state_d = SUP_OFF;   // blackout
                else if (vcc_ok && mode_nmos) state_d = SUP_HOLD; // trip-nmos
                else if (vcc_ok)              state_d = SUP_CWAIT; // trip-cmos
            end
            SUP_CWAIT: begin
                if (!vbat_ok)     state_d = SUP_OFF;
                else if (!vcc_ok) state_d = SUP_LOWVCC;     // brown-out
                else if (in_ok)   state_d = SUP_HOLD;       // input-good
            end
            SUP_HOLD: begin
                if (!vbat_ok)      state_d = SUP_OFF;
                else if (!vcc_ok)  state_d = SUP_LOWVCC;
                else if (tmr_zero) state_d = SUP_RUN;       // hold-done
            end
            SUP_RUN: begin
                if (!vbat_ok)                  state_d = SUP_OFF;
                else if (!vcc_ok)              state_d = SUP_LOWVCC;
                else if (tmr_zero && !stb_rise) state_d = SUP_HOLD; // dog-bite
            end
            default: state_d = SUP_OFF;
        endcase
    end

    // outputs and timer control
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = HOLD_LD;
        if (state_d == SUP_HOLD && state_q != SUP_HOLD) begin
            tmr_load = 1'b1;
            tmr_val  = HOLD_LD;
        end else if (state_d == SUP_RUN &&
                     (state_q != SUP_RUN || stb_rise)) begin
            tmr_load = 1'b1;
            tmr_val  = WDOG_LD;
        end
        tmr_dec  = (state_q == SUP_HOLD) || (state_q == SUP_RUN);
        nmi_trig = (state_q == SUP_LOWVCC && state_d == SUP_HOLD) ||
                   (supervised && in_fall) ||
                   (supervised && stb_rise && !in_ok);
        nmi_en   = !(mode_nmos && low_side);
        rst_act  = (state_q == SUP_HOLD) || (mode_nmos && low_side);
        ce_block = low_side;
        pwr_fail = (state_q == SUP_OFF);
    end
endmodule

// File: rtl/pwr_supervisor_seq.sv
module pwr_supervisor_seq
    import pss_pkg::*;
#(
    parameter int RST_HOLD = 200,
    parameter int WDOG_CYC = 1000,
    parameter int NMI_W    = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_ok,
    input  logic vcc_ok,
    input  logic vbat_ok,
    input  logic mode_nmos,
    input  logic strobe,
    output logic nmi_n,
    output logic nmi_oe,
    output logic rst_hi,
    output logic rst_lo_n,
    output logic ram_ce_n,
    output logic pf,
    output logic pf_n
);
    localparam int MAXN = max2(max2(RST_HOLD, WDOG_CYC), 2);
    localparam int CW   = $clog2(MAXN + 1);

    logic          tmr_load, tmr_dec, tmr_zero;
    logic [CW-1:0] tmr_val;
    logic          nmi_trig, nmi_en, nmi_act;
    logic          rst_act, ce_block, pwr_fail;

    pss_fsm #(
        .CW       (CW),
        .RST_HOLD (RST_HOLD),
        .WDOG_CYC (WDOG_CYC)
    ) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_ok    (in_ok),
        .vcc_ok   (vcc_ok),
        .vbat_ok  (vbat_ok),
        .mode_nmos(mode_nmos),
        .strobe   (strobe),
        .tmr_zero (tmr_zero),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .tmr_dec  (tmr_dec),
        .nmi_trig (nmi_trig),
        .nmi_en   (nmi_en),
        .rst_act  (rst_act),
        .ce_block (ce_block),
        .pwr_fail (pwr_fail)
    );

    pss_timer #(.CW(CW)) tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .dec      (tmr_dec),
        .zero     (tmr_zero)
    );

    pss_nmi_pulse #(.NMI_W(NMI_W)) nmi_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig   (nmi_trig),
        .en     (nmi_en),
        .active (nmi_act)
    );

    assign nmi_oe   = nmi_en;
    assign nmi_n    = ~(nmi_act & nmi_en);
    assign rst_hi   = rst_act;
    assign rst_lo_n = ~rst_act;
    assign ram_ce_n = ce_block;
    assign pf       = pwr_fail;
    assign pf_n     = ~pwr_fail;
endmodule

// File: rtl/pss_checker.sv
module pss_checker (
    input logic clk,
    input logic rst_n,
    input logic in_ok,
    input logic vcc_ok,
    input logic vbat_ok,
    input logic mode_nmos,
    input logic strobe,
    input logic nmi_n,
    input logic nmi_oe,
    input logic rst_hi,
    input logic rst_lo_n,
    input logic ram_ce_n,
    input logic pf,
    input logic pf_n
);
    logic in_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) in_seen_q <= 1'b0;
        else        in_seen_q <= in_ok;
    end

    AST_RST_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        rst_lo_n == !rst_hi);                                       // R13
    AST_PF_LOW_BAT: assert property (@(posedge clk) disable iff (!rst_n)
        !vbat_ok |=> (pf && !pf_n));                                // R6
    AST_PF_GOOD_BAT: assert property (@(posedge clk) disable iff (!rst_n)
        vbat_ok |=> (!pf && pf_n));                                 // R6
    AST_CMOS_NO_RST: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_nmos && !vcc_ok) |=> (mode_nmos || !rst_hi));        // R3
    AST_NMOS_LOW_RST: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_nmos && !vcc_ok) |=> (!mode_nmos || (rst_hi && !rst_lo_n))); // R4
    AST_RAM_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!vcc_ok || !vbat_ok) |=> ram_ce_n);                        // R5
    AST_NMI_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_nmos && !vcc_ok) |=> (!mode_nmos || !nmi_oe));        // R7
    AST_NMI_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_ce_n && vcc_ok && vbat_ok && in_seen_q && !in_ok) |=> !nmi_n); // R1
endmodule

bind pwr_supervisor_seq pss_checker chk_i (.*);

// File: tb/pwr_supervisor_seq_tb_top.sv
`timescale 1ns/1ps
module pwr_supervisor_seq_tb_top;
    localparam int RST_HOLD = 8;
    localparam int WDOG_CYC = 20;
    localparam int NMI_W    = 3;

    logic clk = 1'b0;
    logic rst_n, in_ok, vcc_ok, vbat_ok, mode_nmos, strobe;
    logic nmi_n, nmi_oe, rst_hi, rst_lo_n, ram_ce_n, pf, pf_n;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwr_supervisor_seq #(
        .RST_HOLD(RST_HOLD), .WDOG_CYC(WDOG_CYC), .NMI_W(NMI_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .in_ok(in_ok), .vcc_ok(vcc_ok),
        .vbat_ok(vbat_ok), .mode_nmos(mode_nmos), .strobe(strobe),
        .nmi_n(nmi_n), .nmi_oe(nmi_oe), .rst_hi(rst_hi), .rst_lo_n(rst_lo_n),
        .ram_ce_n(ram_ce_n), .pf(pf), .pf_n(pf_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic t_reset();
        chk("R6 pf in reset", pf, 1);
        chk("R6 pf_n in reset", pf_n, 0);
        chk("R4 rst_hi in reset", rst_hi, 1);
        chk("R13 rst_lo_n in reset", rst_lo_n, 0);
        chk("R5 ram_ce_n in reset", ram_ce_n, 1);
        chk("R7 nmi_oe in reset", nmi_oe, 0);
    endtask

    task automatic t_nmos_powerup();
        int nr, nn;
        vbat_ok = 1'b1;
        step();
        chk("R6 pf after battery good", pf, 0);
        chk("R6 pf_n after battery good", pf_n, 1);
        chk("R4 rst_hi below trip", rst_hi, 1);
        chk("R5 ram_ce_n below trip", ram_ce_n, 1);
        chk("R7 nmi_oe below trip", nmi_oe, 0);
        vcc_ok = 1'b1;
        in_ok  = 1'b1;
        nr = 0; nn = 0;
        for (int i = 0; i < RST_HOLD + 2; i++) begin
            step();
            if (rst_hi) nr++;
            if (!nmi_n) nn++;
        end
        chk("R8 reset hold length", nr, RST_HOLD);
        chk("R8 power-up nmi length", nn, NMI_W);
        chk("R7 nmi_oe above trip", nmi_oe, 1);
        chk("R5 ram_ce_n above trip", ram_ce_n, 0);
    endtask

    task automatic t_watchdog();
        int bad_rst, bad_nmi, n, m;
        bad_rst = 0; bad_nmi = 0;
        for (int k = 0; k < 6; k++) begin
            strobe = 1'b1;
            step();
            strobe = 1'b0;
            if (rst_hi) bad_rst++;
            if (!nmi_n) bad_nmi++;
            for (int j = 0; j < 4; j++) begin
                step();
                if (rst_hi) bad_rst++;
                if (!nmi_n) bad_nmi++;
            end
        end
        chk("R11 strobes keep reset off", bad_rst, 0);
        chk("R2 strobe with input high gives no nmi", bad_nmi, 0);
        strobe = 1'b1;
        step();
        strobe = 1'b0;
        n = 0;
        while (!rst_hi && n < WDOG_CYC + 5) begin
            n++;
            step();
        end
        chk("R10 watchdog period", n, WDOG_CYC);
        m = 0;
        while (rst_hi && m < RST_HOLD + 5) begin
            m++;
            step();
        end
        chk("R10 watchdog reset length", m, RST_HOLD);
    endtask

    task automatic t_nmi_poll();
        int n;
        in_ok = 1'b0;
        step();
        n = 0;
        while (!nmi_n && n < 20) begin n++; step(); end
        chk("R1 nmi on input fall", n, NMI_W);
        strobe = 1'b1;
        step();
        strobe = 1'b0;
        n = 0;
        while (!nmi_n && n < 20) begin n++; step(); end
        chk("R2 nmi on strobe while input low", n, NMI_W);
        n = 0;
        for (int i = 0; i < 12; i++) begin
            strobe = (i == 0 || i == 2);
            step();
            if (!nmi_n) n++;
        end
        strobe = 1'b0;
        chk("R12 retriggered pulse length", n, NMI_W + 2);
        in_ok = 1'b1;
        strobe = 1'b1;
        step();
        strobe = 1'b0;
        step();
        chk("R10 no reset while polled", rst_hi, 0);
    endtask

    task automatic t_nmos_powerdown();
        vcc_ok = 1'b0;
        step();
        chk("R4 nmos rst_hi on supply drop", rst_hi, 1);
        chk("R4 nmos rst_lo_n on supply drop", rst_lo_n, 0);
        chk("R5 ram_ce_n on supply drop", ram_ce_n, 1);
        chk("R7 nmi released on supply drop", nmi_oe, 0);
        chk("R6 pf stays off above battery", pf, 0);
        vbat_ok = 1'b0;
        step();
        chk("R6 pf on battery drop", pf, 1);
        chk("R6 pf_n on battery drop", pf_n, 0);
        vbat_ok = 1'b1;
        step();
        chk("R6 pf clears on battery return", pf, 0);
        chk("R6 pf_n sets on battery return", pf_n, 1);
    endtask

    task automatic t_cmos_powerup();
        int bad, m;
        mode_nmos = 1'b0;
        step();
        chk("R3 cmos no reset below trip", rst_hi, 0);
        chk("R7 cmos nmi_oe below trip", nmi_oe, 1);
        in_ok  = 1'b0;
        vcc_ok = 1'b1;
        step();
        chk("R5 ram_ce_n cmos wait", ram_ce_n, 0);
        bad = 0;
        for (int i = 0; i < 10; i++) begin
            step();
            if (rst_hi) bad++;
        end
        chk("R9 no reset before input good", bad, 0);
        in_ok = 1'b1;
        step();
        m = 0;
        while (rst_hi && m < RST_HOLD + 5) begin m++; step(); end
        chk("R9 cmos reset length", m, RST_HOLD);
    endtask

    task automatic t_cmos_powerdown();
        int bad;
        vcc_ok = 1'b0;
        step();
        chk("R5 cmos ram_ce_n on supply drop", ram_ce_n, 1);
        chk("R7 cmos nmi_oe on supply drop", nmi_oe, 1);
        bad = 0;
        for (int i = 0; i < 6; i++) begin
            if (rst_hi) bad++;
            step();
        end
        chk("R3 cmos no reset on supply drop", bad, 0);
        chk("R13 rst_lo_n high", rst_lo_n, 1);
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog timeout actual=0 expected=1");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; in_ok = 1'b0; vcc_ok = 1'b0; vbat_ok = 1'b0;
        mode_nmos = 1'b1; strobe = 1'b0;
        repeat (3) step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_nmos_powerup();
        t_watchdog();
        t_nmi_poll();
        t_nmos_powerdown();
        t_cmos_powerup();
        t_cmos_powerdown();
        finish_run();
    end
endmodule